// File: doc/BRIEF.md
# Subframe Descriptor Sequencer

The sequencer walks a frame that is split into subframes. Each subframe is governed by one of a pair of frame control descriptors: the transmit direction owns descriptors 0 and 1, the receive direction owns descriptors 2 and 3. When a frame starts, the sequencer chooses a descriptor from the pair and loads that descriptor's word count into the subframe counter. The counter then steps down by one on every word strobe. The word that empties the counter closes the subframe, and a selection policy then picks the descriptor for the next subframe.

Each direction has its own 2-bit policy input. One policy reloads the first descriptor every time. One starts on the first descriptor and then alternates. One starts on the first descriptor and stays on the second for the rest of the frame. The last keeps one descriptor for the whole frame and alternates from frame to frame. While a frame is running, the control fields of the active descriptor drive the downstream CRC, whitening and trailer logic. A frame-end input closes the frame at any time.

Top module: `sfseq_top`

## Requirements
- R1: After reset, busy, subEnd, subCnt, activeIdx, txSelStat and rxSelStat are all 0.
- R2: A frameStart pulse starts a frame in the direction given by dirRx (0 = transmit, 1 = receive). On the next cycle busy is 1 and subCnt holds the word count of the chosen descriptor. activeIdx is {dirRx, pair member}, so transmit uses indices 0 and 1 and receive uses 2 and 3.
- R3: Each wordStrobe in a running subframe lowers subCnt by one. A word strobe when subCnt is 1 or 0 ends the subframe and leaves subCnt at 0, so a word count of 0 closes its subframe on the first word.
- R4: subEnd is high for exactly one cycle, the cycle after the edge that took the ending word. On the following edge the next descriptor is selected and its word count is loaded. A wordStrobe during that reload cycle is ignored.
- R5: Policy 0 (mode value 0) selects the first descriptor of the pair for every subframe.
- R6: Policy 1 (mode value 1) selects the first descriptor for the first subframe and then alternates second, first, second, and so on.
- R7: Policy 2 (mode value 2) selects the first descriptor for the first subframe and the second descriptor for every later subframe of the frame.
- R8: Policy 3 (mode value 3) keeps one descriptor for every subframe of a frame and alternates it from frame to frame. Each direction keeps its own alternation state, which starts on the first descriptor after reset and is changed only by frames that run in policy 3.
- R9: txSelStat and rxSelStat show which member of the pair (0 = first, 1 = second) the transmit and receive directions last selected.
- R10: Descriptor bit fields are: [7:0] word count, [9:8] buffer select, [10] include CRC, [11] calculate CRC, [13:12] CRC skip words, [14] skip whitening, [15] add trailing data, [16] exclude from word count. While busy, the active descriptor's fields appear on the matching outputs. While idle, all of those outputs are 0.
- R11: frameEnd returns the sequencer to idle on the next cycle with subCnt at 0. It overrides a word strobe in the same cycle, so no subEnd is produced.
- R12: frameStart during a running frame restarts it with the policy's first descriptor. frameStart takes priority over frameEnd in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | Start-of-frame pulse |
| frameEnd | input | 1 | End-of-frame / abort pulse |
| wordStrobe | input | 1 | One pulse per data word |
| dirRx | input | 1 | Direction of the frame being started: 1 receive, 0 transmit |
| txMode | input | 2 | Transmit selection policy |
| rxMode | input | 2 | Receive selection policy |
| txDescA | input | 17 | Descriptor 0 |
| txDescB | input | 17 | Descriptor 1 |
| rxDescA | input | 17 | Descriptor 2 |
| rxDescB | input | 17 | Descriptor 3 |
| busy | output | 1 | Frame in progress |
| activeIdx | output | 2 | Index of the active descriptor |
| txSelStat | output | 1 | Last transmit pair member selected |
| rxSelStat | output | 1 | Last receive pair member selected |
| subCnt | output | 8 | Subframe word counter |
| subEnd | output | 1 | End-of-subframe pulse |
| bufSel | output | 2 | Active buffer select |
| inclCrc | output | 1 | Active include-CRC bit |
| calcCrc | output | 1 | Active calculate-CRC bit |
| crcSkip | output | 2 | Active CRC leading-word skip count |
| skipWhite | output | 1 | Active skip-whitening bit |
| addTrail | output | 1 | Active add-trailing-data bit |
| exclWcnt | output | 1 | Active exclude-from-word-count bit |

## Verification
Two events can fall in the same cycle. The first pair is a frame end and the word that would empty the counter. The bench provokes it by pulsing frameEnd and wordStrobe together with subCnt at 1, and it requires idle with no subEnd pulse on the next cycle. The second pair is a word strobe and the descriptor reload that follows an ending word. The bench strobes during the reload cycle and requires the freshly loaded count, not that count minus one. A frameStart that coincides with frameEnd must restart the frame on the policy's first descriptor.

// File: rtl/sfseq_pkg.sv
package sfseq_pkg;
  localparam int CNT_W  = 8;
  localparam int BUF_W  = 2;
  localparam int SKIP_W = 2;
  localparam int NUM_DESC = 4;
  localparam int IDX_W  = $clog2(NUM_DESC);

  typedef struct packed {
    logic              exclWcnt;
    logic              addTrail;
    logic              skipWhite;
    logic [SKIP_W-1:0] crcSkip;
    logic              calcCrc;
    logic              inclCrc;
    logic [BUF_W-1:0]  bufSel;
    logic [CNT_W-1:0]  wordCnt;
  } descT;

  localparam int DESC_W = $bits(descT);

  typedef enum logic [1:0] {
    MODE_RELOAD = 2'd0,
    MODE_ALT    = 2'd1,
    MODE_STICK  = 2'd2,
    MODE_FRAME  = 2'd3
  } selModeT;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RUN    = 2'd1,
    ST_RELOAD = 2'd2
  } seqStateT;

  typedef struct packed {
    logic             load;
    logic             dec;
    logic             clr;
    logic [IDX_W-1:0] loadIdx;
  } seqStrbT;
endpackage

// File: rtl/sfseq_ctrl.sv
module sfseq_ctrl
  import sfseq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameStart,
  input  logic             frameEnd,
  input  logic             wordStrobe,
  input  logic             dirRx,
  input  logic [1:0]       txMode,
  input  logic [1:0]       rxMode,
  input  logic             lastWord,
  output seqStrbT          strb,
  output logic             busy,
  output logic [IDX_W-1:0] curIdx,
  output logic             txSelStat,
  output logic             rxSelStat,
  output logic             subEnd
);
  seqStateT state;
  logic     dirQ;
  logic     selQ;
  logic     parTx;
  logic     parRx;
  logic     endQ;
  selModeT  startMode;
  selModeT  runMode;
  logic     startSel;
  logic     nextSel;

  // policy that applies to a frame being started, and to the running frame
  always_comb begin
    startMode = selModeT'(dirRx ? rxMode : txMode);
    runMode   = selModeT'(dirQ ? rxMode : txMode);
    startSel  = (startMode == MODE_FRAME) ? (dirRx ? parRx : parTx) : 1'b0;
    case (runMode)
      MODE_RELOAD: nextSel = 1'b0;
      MODE_ALT:    nextSel = ~selQ;
      MODE_STICK:  nextSel = 1'b1;
      default:     nextSel = selQ;
    endcase
  end

  // strobes towards the datapath
  always_comb begin
    strb.load    = frameStart | ((state == ST_RELOAD) & ~frameEnd);
    strb.loadIdx = frameStart ? {dirRx, startSel} : {dirQ, nextSel};
    strb.clr     = ~frameStart & frameEnd;
    strb.dec     = ~frameStart & ~frameEnd & (state == ST_RUN) & wordStrobe;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      dirQ      <= 1'b0;
      selQ      <= 1'b0;
      parTx     <= 1'b0;
      parRx     <= 1'b0;
      txSelStat <= 1'b0;
      rxSelStat <= 1'b0;
      endQ      <= 1'b0;
    end else begin
      endQ <= 1'b0;
      if (frameStart) begin
        state <= ST_RUN;
        dirQ  <= dirRx;
        selQ  <= startSel;
        if (dirRx) rxSelStat <= startSel;
        else       txSelStat <= startSel;
        if (startMode == MODE_FRAME) begin
          if (dirRx) parRx <= ~parRx;
          else       parTx <= ~parTx;
        end
      end else if (frameEnd) begin
        state <= ST_IDLE;
      end else begin
        case (state)
          ST_RUN: begin
            if (wordStrobe && lastWord) begin
              endQ  <= 1'b1;
              state <= ST_RELOAD;
            end
          end
          ST_RELOAD: begin
            selQ  <= nextSel;
            if (dirQ) rxSelStat <= nextSel;
            else      txSelStat <= nextSel;
            state <= ST_RUN;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign busy   = (state != ST_IDLE);
  assign curIdx = busy ? {dirQ, selQ} : '0;
  assign subEnd = endQ;

  a_r4_end_single: assert property (@(posedge clk) disable iff (!rstN)
    endQ |=> !endQ);
  a_r11_abort_idle: assert property (@(posedge clk) disable iff (!rstN)
    (frameEnd && !frameStart) |=> (state == ST_IDLE && !endQ));
  a_r7_stick_second: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RELOAD && runMode == MODE_STICK && !frameStart && !frameEnd) |=> selQ);
  a_r8_tx_parity_flip: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && !dirRx && startMode == MODE_FRAME) |=> (parTx != $past(parTx)));
  a_r12_restart_runs: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> (state == ST_RUN && !endQ));
endmodule

// File: rtl/sfseq_data.sv
module sfseq_data
  import sfseq_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  seqStrbT                strb,
  input  logic                   busy,
  input  logic [IDX_W-1:0]       curIdx,
  input  descT [NUM_DESC-1:0]    descs,
  output logic [CNT_W-1:0]       subCnt,
  output logic                   lastWord,
  output logic [BUF_W-1:0]       bufSel,
  output logic                   inclCrc,
  output logic                   calcCrc,
  output logic [SKIP_W-1:0]      crcSkip,
  output logic                   skipWhite,
  output logic                   addTrail,
  output logic                   exclWcnt
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt;
  descT             actDesc;

  always_ff @(posedge clk) begin
    if (!rstN)            cnt <= '0;
    else if (strb.clr)    cnt <= '0;
    else if (strb.load)   cnt <= descs[strb.loadIdx].wordCnt;
    else if (strb.dec)    cnt <= (cnt == '0) ? '0 : cnt - ONE;
  end

  assign lastWord = (cnt <= ONE);
  assign subCnt   = cnt;

  always_comb begin
    actDesc   = busy ? descs[curIdx] : '0;
    bufSel    = actDesc.bufSel;
    inclCrc   = actDesc.inclCrc;
    calcCrc   = actDesc.calcCrc;
    crcSkip   = actDesc.crcSkip;
    skipWhite = actDesc.skipWhite;
    addTrail  = actDesc.addTrail;
    exclWcnt  = actDesc.exclWcnt;
  end

  a_r3_count_down: assert property (@(posedge clk) disable iff (!rstN)
    (strb.dec && cnt > ONE) |=> (cnt == $past(cnt) - ONE));
  a_r11_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    strb.clr |=> (cnt == '0));
endmodule

// File: rtl/sfseq_top.sv
module sfseq_top
  import sfseq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStart,
  input  logic              frameEnd,
  input  logic              wordStrobe,
  input  logic              dirRx,
  input  logic [1:0]        txMode,
  input  logic [1:0]        rxMode,
  input  logic [DESC_W-1:0] txDescA,
  input  logic [DESC_W-1:0] txDescB,
  input  logic [DESC_W-1:0] rxDescA,
  input  logic [DESC_W-1:0] rxDescB,
  output logic              busy,
  output logic [IDX_W-1:0]  activeIdx,
  output logic              txSelStat,
  output logic              rxSelStat,
  output logic [CNT_W-1:0]  subCnt,
  output logic              subEnd,
  output logic [BUF_W-1:0]  bufSel,
  output logic              inclCrc,
  output logic              calcCrc,
  output logic [SKIP_W-1:0] crcSkip,
  output logic              skipWhite,
  output logic              addTrail,
  output logic              exclWcnt
);
  seqStrbT             strb;
  logic                lastWord;
  descT [NUM_DESC-1:0] descs;

  assign descs[0] = descT'(txDescA);
  assign descs[1] = descT'(txDescB);
  assign descs[2] = descT'(rxDescA);
  assign descs[3] = descT'(rxDescB);

  sfseq_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .frameEnd(frameEnd),
    .wordStrobe(wordStrobe), .dirRx(dirRx), .txMode(txMode), .rxMode(rxMode),
    .lastWord(lastWord), .strb(strb), .busy(busy), .curIdx(activeIdx),
    .txSelStat(txSelStat), .rxSelStat(rxSelStat), .subEnd(subEnd)
  );

  sfseq_data uData (
    .clk(clk), .rstN(rstN), .strb(strb), .busy(busy), .curIdx(activeIdx),
    .descs(descs), .subCnt(subCnt), .lastWord(lastWord), .bufSel(bufSel),
    .inclCrc(inclCrc), .calcCrc(calcCrc), .crcSkip(crcSkip),
    .skipWhite(skipWhite), .addTrail(addTrail), .exclWcnt(exclWcnt)
  );
endmodule

// File: tb/tb_sfseq_top.sv
module tb_sfseq_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameStart = 1'b0, frameEnd = 1'b0, wordStrobe = 1'b0, dirRx = 1'b0;
  logic [1:0]  txMode = 2'd0, rxMode = 2'd0;
  logic [16:0] txDescA = '0, txDescB = '0, rxDescA = '0, rxDescB = '0;
  logic        busy, txSelStat, rxSelStat, subEnd;
  logic [1:0]  activeIdx, bufSel, crcSkip;
  logic [7:0]  subCnt;
  logic        inclCrc, calcCrc, skipWhite, addTrail, exclWcnt;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  sfseq_top dut (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .frameEnd(frameEnd),
    .wordStrobe(wordStrobe), .dirRx(dirRx), .txMode(txMode), .rxMode(rxMode),
    .txDescA(txDescA), .txDescB(txDescB), .rxDescA(rxDescA), .rxDescB(rxDescB),
    .busy(busy), .activeIdx(activeIdx), .txSelStat(txSelStat), .rxSelStat(rxSelStat),
    .subCnt(subCnt), .subEnd(subEnd), .bufSel(bufSel), .inclCrc(inclCrc),
    .calcCrc(calcCrc), .crcSkip(crcSkip), .skipWhite(skipWhite),
    .addTrail(addTrail), .exclWcnt(exclWcnt)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one cycle with the given pulses, ends at the next falling edge
  task automatic cyc(input logic ws, input logic fs, input logic fe);
    wordStrobe = ws; frameStart = fs; frameEnd = fe;
    @(negedge clk);
    wordStrobe = 1'b0; frameStart = 1'b0; frameEnd = 1'b0;
  endtask

  task automatic startFrame(input logic rx);
    dirRx = rx;
    cyc(1'b0, 1'b1, 1'b0);
  endtask

  task automatic tReset;
    chk("R1 busy", busy, 0);
    chk("R1 subEnd", subEnd, 0);
    chk("R1 subCnt", subCnt, 0);
    chk("R1 activeIdx", activeIdx, 0);
    chk("R1 selStat", {txSelStat, rxSelStat}, 0);
  endtask

  task automatic tMode0;
    txMode = 2'd0; txDescA = 17'd2; txDescB = 17'd3;
    startFrame(1'b0);
    chk("R2 busy", busy, 1);
    chk("R2 count", subCnt, 2);
    chk("R2 idx", activeIdx, 0);
    cyc(1'b1, 1'b0, 1'b0);
    chk("R3 dec", subCnt, 1);
    cyc(1'b1, 1'b0, 1'b0);
    chk("R4 pulse", subEnd, 1);
    chk("R3 zero", subCnt, 0);
    cyc(1'b1, 1'b0, 1'b0);  // strobe in reload cycle is dropped
    chk("R4 pulse one cycle", subEnd, 0);
    chk("R4 reload ignores strobe", subCnt, 2);
    chk("R5 first again", activeIdx, 0);
    cyc(1'b0, 1'b0, 1'b1);
  endtask

  task automatic tMode1;
    txMode = 2'd1; txDescA = 17'd1; txDescB = 17'd2;
    startFrame(1'b0);
    chk("R6 first", activeIdx, 0);
    cyc(1'b1, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b0);
    chk("R6 second", activeIdx, 1);
    chk("R6 count B", subCnt, 2);
    chk("R9 tx stat", txSelStat, 1);
    cyc(1'b1, 1'b0, 1'b0);
    cyc(1'b1, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b0);
    chk("R6 back to first", activeIdx, 0);
    chk("R9 tx stat back", txSelStat, 0);
    cyc(1'b1, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b0);
    chk("R6 second again", activeIdx, 1);
    cyc(1'b0, 1'b0, 1'b1);
  endtask

  task automatic tMode2;
    txMode = 2'd2; txDescA = 17'd1; txDescB = 17'd1;
    startFrame(1'b0);
    chk("R7 first", activeIdx, 0);
    cyc(1'b1, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b0);
    chk("R7 second", activeIdx, 1);
    cyc(1'b1, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b0);
    chk("R7 stays second", activeIdx, 1);
    cyc(1'b0, 1'b0, 1'b1);
  endtask

  task automatic tMode3;
    rxMode = 2'd3; rxDescA = 17'd3; rxDescB = 17'd4;
    startFrame(1'b1);
    chk("R8 frame1 first", activeIdx, 2);
    chk("R8 frame1 count", subCnt, 3);
    chk("R9 rx stat", rxSelStat, 0);
    repeat (3) cyc(1'b1, 1'b0, 1'b0);
    chk("R4 rx end", subEnd, 1);
    cyc(1'b0, 1'b0, 1'b0);
    chk("R8 same within frame", activeIdx, 2);
    cyc(1'b0, 1'b0, 1'b1);
    startFrame(1'b1);
    chk("R8 frame2 second", activeIdx, 3);
    chk("R8 frame2 count", subCnt, 4);
    chk("R9 rx stat second", rxSelStat, 1);
    cyc(1'b0, 1'b0, 1'b1);
    txMode = 2'd3; txDescA = 17'd6;
    startFrame(1'b0);
    chk("R8 tx parity independent", activeIdx, 0);
    chk("R9 rx stat kept", rxSelStat, 1);
    cyc(1'b0, 1'b0, 1'b1);
  endtask

  task automatic tFields;
    txMode = 2'd0; txDescA = 17'h17605;
    startFrame(1'b0);
    chk("R10 count", subCnt, 5);
    chk("R10 bufSel", bufSel, 2);
    chk("R10 inclCrc", inclCrc, 1);
    chk("R10 calcCrc", calcCrc, 0);
    chk("R10 crcSkip", crcSkip, 3);
    chk("R10 skipWhite", skipWhite, 1);
    chk("R10 addTrail", addTrail, 0);
    chk("R10 exclWcnt", exclWcnt, 1);
    cyc(1'b0, 1'b0, 1'b1);
    chk("R10 idle zero", {bufSel, inclCrc, calcCrc, crcSkip, skipWhite, addTrail, exclWcnt}, 0);
  endtask

  task automatic tZeroCount;
    txMode = 2'd0; txDescA = 17'd0;
    startFrame(1'b0);
    chk("R3 zero load", subCnt, 0);
    cyc(1'b1, 1'b0, 1'b0);
    chk("R3 zero ends", subEnd, 1);
    chk("R3 zero stays", subCnt, 0);
    cyc(1'b0, 1'b0, 1'b1);
  endtask

  task automatic tAbort;
    txMode = 2'd0; txDescA = 17'd1;
    startFrame(1'b0);
    cyc(1'b1, 1'b0, 1'b1);
    chk("R11 idle", busy, 0);
    chk("R11 no pulse", subEnd, 0);
    chk("R11 count cleared", subCnt, 0);
    cyc(1'b0, 1'b0, 1'b0);
    chk("R11 no late pulse", subEnd, 0);
  endtask

  task automatic tRestart;
    txMode = 2'd1; txDescA = 17'd1; txDescB = 17'd5;
    startFrame(1'b0);
    cyc(1'b1, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b0);
    cyc(1'b1, 1'b0, 1'b0);
    chk("R12 mid frame", subCnt, 4);
    dirRx = 1'b0;
    cyc(1'b0, 1'b1, 1'b1);
    chk("R12 still busy", busy, 1);
    chk("R12 first desc", activeIdx, 0);
    chk("R12 reloaded", subCnt, 1);
    chk("R9 tx stat restart", txSelStat, 0);
    cyc(1'b0, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tMode0();
    tMode1();
    tMode2();
    tMode3();
    tFields();
    tZeroCount();
    tAbort();
    tRestart();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule